// File: doc/BRIEF.md
# Cascaded Interrupt Request Controller

The controller collects interrupt requests from up to 94 external sources and combines them into one interrupt request line for a processor. It has three identical units of 32 lines each: a main unit and two subordinate units. The output of subordinate unit 1 drives line 0 of the main unit, and the output of subordinate unit 2 drives line 1. The other thirty main lines come from external sources. A subordinate request reaches the processor only when its own line is enabled and the matching cascade line in the main unit is also enabled.

Each line has three per-bit settings: an enable, a polarity and a sensing type (level or edge). A raw status word holds the current request state of each line. Level lines follow their input. Edge lines capture a transition and keep it until software clears it with a write-one-to-clear access. Each unit drives its output high while any line is both requesting and enabled. The masked status of the main unit is also provided on a port.

External inputs pass through a synchroniser before they are used. All outputs, including read data, are registered. Software reaches every register through a single-cycle write and registered-read port, using a word address.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Reset clears the following: every enable, polarity and type bit in all three units, the `irq` output, the `main_masked` output and the read data register.
- R2: The word address is split as {unit[4:3], register[2:0]}. Unit values: 0 = main, 1 = subordinate 1, 2 = subordinate 2. Register values: 0 = enable, 1 = raw status (write one to clear), 2 = masked status (read-only), 3 = polarity, 4 = type. Read data appears on `bus_rdata` one clock after the address. An unused unit or register address reads as zero and ignores writes. A write to the masked status register changes nothing.
- R3: A polarity bit of 1 makes the line active high (rising edge). A polarity bit of 0 makes it active low (falling edge).
- R4: When a line's type bit is 0, the line is level sensitive. Its raw status bit shows the polarity-corrected synchronised input, and write-one-to-clear accesses do not affect it.
- R5: When a line's type bit is 1, the line is edge sensitive. A transition into the active state sets its raw status bit. The bit stays set after the source goes inactive and is removed only by writing 1 to that bit of the raw status register.
- R6: Masked status equals raw status AND enable. Clearing an enable bit removes the line from masked status and from the unit output, but leaves that line's raw status, polarity and type unchanged.
- R7: `irq` is high exactly when `main_masked` is nonzero. Both outputs come from the main unit's registered state.
- R8: Subordinate unit 1 drives main line 0 and subordinate unit 2 drives main line 1. Each subordinate output is active high. The main unit's polarity, type and enable bits on a cascade line act on the whole subordinate unit behind it. For example, a main polarity of 0 on a cascade line turns an idle subordinate into an active request.
- R9: A change on a main external line reaches `irq` on the 4th rising clock edge after it is applied. A change on a subordinate line reaches `irq` on the 6th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address {unit, register} |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| main_src | input | 30 | External requests for main lines 2 to 31 (bit n is line n) |
| sub1_src | input | 32 | External requests for subordinate unit 1 |
| sub2_src | input | 32 | External requests for subordinate unit 2 |
| irq | output | 1 | Combined interrupt request |
| main_masked | output | 32 | Main unit raw status AND enable |

## Verification
Every result has a fixed latency, counted in rising clock edges from the falling edge at which the bench changes an input:
- Read data: due after one edge.
- A write: takes effect at the next edge.
- A main external source: reaches raw status after three edges, and reaches `irq` and `main_masked` after four.
- A subordinate source: needs two more edges, because it also passes through the subordinate unit's status and output registers.

The latency checks sample `irq` at the falling edge just before the due edge, expecting it still low, and again at the falling edge just after it, expecting it high. All other checks wait eight cycles after a stimulus before they sample, which is well past every latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word address layout: {unit select, register offset}
  localparam int unsigned OFS_W  = 3;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned ADDR_W = OFS_W + SEL_W;

  // Number of subordinate units cascaded into the lowest main lines
  localparam int unsigned CASCADE_LINES = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_ENABLE = 3'd0,
    OFS_RAW    = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_POL    = 3'd3,
    OFS_TYPE   = 3'd4
  } reg_ofs_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_MAIN = 2'd0,
    SEL_SUB1 = 2'd1,
    SEL_SUB2 = 2'd2
  } unit_sel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
  import irqc_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic [LINES-1:0] wr_data,
  output logic [LINES-1:0] rd_word,
  output logic [LINES-1:0] masked,
  output logic             unit_out
);

  logic [LINES-1:0] en_q, pol_q, type_q, raw_q, prev_q, masked_q;
  logic             out_q;

  logic [LINES-1:0] act, prev_act, edge_hit, clr_mask, raw_next;
  logic             wr_enable, wr_raw, wr_pol, wr_type;

  // Polarity-corrected view; history is corrected with the current
  // polarity so that a polarity change alone never forms an edge.
  assign act      = line_in ~^ pol_q;
  assign prev_act = prev_q ~^ pol_q;
  assign edge_hit = act & ~prev_act;

  assign wr_enable = wr_en && (reg_ofs_e'(reg_ofs) == OFS_ENABLE);
  assign wr_raw    = wr_en && (reg_ofs_e'(reg_ofs) == OFS_RAW);
  assign wr_pol    = wr_en && (reg_ofs_e'(reg_ofs) == OFS_POL);
  assign wr_type   = wr_en && (reg_ofs_e'(reg_ofs) == OFS_TYPE);

  assign clr_mask = wr_raw ? wr_data : '0;

  // Edge lines: hold, drop on clear, a fresh edge wins over a clear.
  // Level lines: follow the corrected input.
  assign raw_next = (type_q & ((raw_q & ~clr_mask) | edge_hit)) |
                    (~type_q & act);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      pol_q    <= '0;
      type_q   <= '0;
      raw_q    <= '0;
      prev_q   <= '0;
      masked_q <= '0;
      out_q    <= 1'b0;
    end else begin
      prev_q   <= line_in;
      raw_q    <= raw_next;
      masked_q <= raw_q & en_q;
      out_q    <= |(raw_q & en_q);
      if (wr_enable) en_q   <= wr_data;
      if (wr_pol)    pol_q  <= wr_data;
      if (wr_type)   type_q <= wr_data;
    end
  end

  always_comb begin
    case (reg_ofs_e'(reg_ofs))
      OFS_ENABLE: rd_word = en_q;
      OFS_RAW:    rd_word = raw_q;
      OFS_MASKED: rd_word = masked_q;
      OFS_POL:    rd_word = pol_q;
      OFS_TYPE:   rd_word = type_q;
      default:    rd_word = '0;
    endcase
  end

  assign masked   = masked_q;
  assign unit_out = out_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && pol_q == '0 && type_q == '0 && !out_q));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (($past(raw_q & type_q) & ~raw_q) == '0));

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((masked_q & ~$past(en_q)) == '0));

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic [NUM_LINES-1:0]              bus_wdata,
  output logic [NUM_LINES-1:0]              bus_rdata,
  input  logic [NUM_LINES-1:CASCADE_LINES]  main_src,
  input  logic [NUM_LINES-1:0]              sub1_src,
  input  logic [NUM_LINES-1:0]              sub2_src,
  output logic                              irq,
  output logic [NUM_LINES-1:0]              main_masked
);

  localparam int unsigned EXT_LINES = NUM_LINES - CASCADE_LINES;

  logic [OFS_W-1:0] reg_ofs;
  logic [SEL_W-1:0] unit_sel;

  assign reg_ofs  = bus_addr[OFS_W-1:0];
  assign unit_sel = bus_addr[ADDR_W-1:OFS_W];

  // Subordinate units
  logic [CASCADE_LINES-1:0][NUM_LINES-1:0] sub_src_arr, sub_sync, sub_rd, sub_masked;
  logic [CASCADE_LINES-1:0]                sub_out;

  assign sub_src_arr[0] = sub1_src;
  assign sub_src_arr[1] = sub2_src;

  for (genvar g = 0; g < CASCADE_LINES; g++) begin : g_sub
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g + 1);

    irqc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (sub_src_arr[g]),
      .dout (sub_sync[g])
    );

    irqc_unit #(.LINES(NUM_LINES)) i_unit (
      .clk      (clk),
      .rst      (rst),
      .line_in  (sub_sync[g]),
      .wr_en    (bus_wr && (unit_sel == MY_SEL)),
      .reg_ofs  (reg_ofs),
      .wr_data  (bus_wdata),
      .rd_word  (sub_rd[g]),
      .masked   (sub_masked[g]),
      .unit_out (sub_out[g])
    );

    // R8
    sub_out_agree_chk: assert property (@(posedge clk) disable iff (rst)
      sub_out[g] == (sub_masked[g] != '0));
  end

  // Main unit: external lines synchronised, cascade lines taken directly
  logic [EXT_LINES-1:0] main_ext_sync;
  logic [NUM_LINES-1:0] main_line, main_rd;
  logic                 main_out;

  irqc_sync #(.WIDTH(EXT_LINES), .STAGES(SYNC_STAGES)) i_main_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (main_src),
    .dout (main_ext_sync)
  );

  assign main_line = {main_ext_sync, sub_out};

  irqc_unit #(.LINES(NUM_LINES)) i_main (
    .clk      (clk),
    .rst      (rst),
    .line_in  (main_line),
    .wr_en    (bus_wr && (unit_sel == SEL_MAIN)),
    .reg_ofs  (reg_ofs),
    .wr_data  (bus_wdata),
    .rd_word  (main_rd),
    .masked   (main_masked),
    .unit_out (main_out)
  );

  assign irq = main_out;

  // Registered read port
  logic [NUM_LINES-1:0] rd_sel, rdata_q;

  always_comb begin
    rd_sel = '0;
    if (unit_sel == SEL_MAIN) rd_sel = main_rd;
    for (int u = 0; u < CASCADE_LINES; u++) begin
      if (unit_sel == SEL_W'(u + 1)) rd_sel = sub_rd[u];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_sel;
  end

  assign bus_rdata = rdata_q;

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (main_masked != '0));

  // R1
  rdata_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0 && !irq));

endmodule

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;

  localparam logic [1:0] U_MAIN = 2'd0, U_SUB1 = 2'd1, U_SUB2 = 2'd2, U_NONE = 2'd3;
  localparam logic [2:0] O_EN = 3'd0, O_RAW = 3'd1, O_MSK = 3'd2, O_POL = 3'd3, O_TYP = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:2] main_src = '0;
  logic [31:0] sub1_src = '0;
  logic [31:0] sub2_src = '0;
  logic        irq;
  logic [31:0] main_masked;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .main_src    (main_src),
    .sub1_src    (sub1_src),
    .sub2_src    (sub2_src),
    .irq         (irq),
    .main_masked (main_masked)
  );

  task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    n_tests++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [2:0] ofs, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = {sel, ofs};
    bus_wdata = data;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, input logic [2:0] ofs, output logic [31:0] data);
    @(negedge clk);
    bus_addr = {sel, ofs};
    @(negedge clk);
    data = bus_rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (5) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 masked in reset", main_masked, 32'd0);
    rst = 1'b0;
    bus_read(U_MAIN, O_EN, v);
    check("R1 main enable", v, 32'd0);
    bus_read(U_SUB1, O_POL, v);
    check("R1 sub1 polarity", v, 32'd0);
    bus_read(U_SUB2, O_TYP, v);
    check("R1 sub2 type", v, 32'd0);
    settle();
    // all lines active low by default, sources idle low, subs idle low
    bus_read(U_MAIN, O_RAW, v);
    check("R3 R4 default active-low level raw", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bus_write(U_MAIN, O_POL, 32'hA5A5_0003);
    bus_read(U_MAIN, O_POL, v);
    check("R2 main polarity readback", v, 32'hA5A5_0003);
    bus_write(U_SUB1, O_TYP, 32'h0000_F00F);
    bus_read(U_SUB1, O_TYP, v);
    check("R2 sub1 type readback", v, 32'h0000_F00F);
    bus_write(U_SUB1, O_TYP, 32'h0);
    bus_write(U_NONE, O_EN, 32'hFFFF_FFFF);
    bus_read(U_NONE, O_EN, v);
    check("R2 unused unit reads zero", v, 32'd0);
    bus_read(U_MAIN, 3'd6, v);
    check("R2 unused offset reads zero", v, 32'd0);
    bus_write(U_MAIN, O_MSK, 32'hFFFF_FFFF);
    bus_read(U_MAIN, O_EN, v);
    check("R2 masked write leaves enable", v, 32'd0);
    bus_read(U_MAIN, O_MSK, v);
    check("R2 masked stays zero", v, 32'd0);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFFF);
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R3 active-high idle raw", v, 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    main_src[5] = 1'b1;
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R4 level raw follows input", v, 32'h0000_0020);
    bus_write(U_MAIN, O_EN, 32'h0000_0020);
    settle();
    check("R7 irq on level line", {31'd0, irq}, 32'd1);
    check("R7 main_masked port", main_masked, 32'h0000_0020);
    bus_write(U_MAIN, O_RAW, 32'h0000_0020);
    bus_read(U_MAIN, O_RAW, v);
    check("R4 clear ignored on level line", v, 32'h0000_0020);
    main_src[5] = 1'b0;
    settle();
    check("R4 level release drops irq", {31'd0, irq}, 32'd0);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFBF);
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R3 active-low line with low input", v & 32'h40, 32'h40);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFFF);
    bus_write(U_MAIN, O_EN, 32'h0);
  endtask

  task automatic t_latency();
    bus_write(U_MAIN, O_EN, 32'h0000_0080);
    @(negedge clk);
    main_src[7] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 main line irq before 4th edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R9 main line irq at 4th edge", {31'd0, irq}, 32'd1);
    main_src[7] = 1'b0;
    settle();
    bus_write(U_MAIN, O_EN, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    bus_write(U_MAIN, O_TYP, 32'h0000_0200);
    bus_write(U_MAIN, O_EN, 32'h0000_0200);
    main_src[9] = 1'b1;
    repeat (2) @(negedge clk);
    main_src[9] = 1'b0;
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R5 rising edge latched", v & 32'h200, 32'h200);
    check("R5 latched edge holds irq", {31'd0, irq}, 32'd1);
    bus_write(U_MAIN, O_RAW, 32'h0000_0200);
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R5 write one clears", v & 32'h200, 32'h0);
    check("R5 irq drops after clear", {31'd0, irq}, 32'd0);
    // falling edge on line 10
    main_src[10] = 1'b1;
    settle();
    bus_write(U_MAIN, O_POL, 32'hFFFF_FBFF);
    bus_write(U_MAIN, O_TYP, 32'h0000_0600);
    main_src[10] = 1'b0;
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R5 R3 falling edge latched", v & 32'h400, 32'h400);
    bus_write(U_MAIN, O_RAW, 32'h0000_0400);
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R5 falling edge cleared", v & 32'h400, 32'h0);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    main_src[9] = 1'b1;
    repeat (2) @(negedge clk);
    main_src[9] = 1'b0;
    settle();
    check("R6 enabled edge line drives irq", {31'd0, irq}, 32'd1);
    bus_write(U_MAIN, O_EN, 32'h0);
    settle();
    check("R6 disabled line irq", {31'd0, irq}, 32'd0);
    check("R6 disabled line masked", main_masked, 32'd0);
    bus_read(U_MAIN, O_RAW, v);
    check("R6 raw kept when disabled", v & 32'h200, 32'h200);
    bus_read(U_MAIN, O_TYP, v);
    check("R6 type kept when disabled", v, 32'h0000_0600);
    bus_read(U_MAIN, O_POL, v);
    check("R6 polarity kept when disabled", v, 32'hFFFF_FFFF);
    bus_write(U_MAIN, O_RAW, 32'h0000_0200);
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    bus_write(U_SUB1, O_POL, 32'hFFFF_FFFF);
    bus_write(U_SUB1, O_EN, 32'h0000_0008);
    sub1_src[3] = 1'b1;
    settle();
    bus_read(U_MAIN, O_RAW, v);
    check("R8 sub1 reaches main line 0", v & 32'h3, 32'h1);
    check("R8 cascade gated by main enable", {31'd0, irq}, 32'd0);
    bus_write(U_MAIN, O_EN, 32'h0000_0001);
    settle();
    check("R8 sub1 irq with main enable", {31'd0, irq}, 32'd1);
    check("R8 main_masked line 0", main_masked, 32'h0000_0001);
    sub1_src[3] = 1'b0;
    settle();
    check("R8 sub1 release", {31'd0, irq}, 32'd0);
    bus_write(U_MAIN, O_EN, 32'h0);
    bus_write(U_SUB2, O_POL, 32'hFFFF_FFFF);
    bus_write(U_SUB2, O_EN, 32'h0000_0010);
    bus_write(U_MAIN, O_EN, 32'h0000_0002);
    settle();
    check("R8 sub2 idle irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    sub2_src[4] = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 sub line irq before 6th edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R9 R8 sub2 irq at 6th edge", {31'd0, irq}, 32'd1);
    sub2_src[4] = 1'b0;
    settle();
    check("R8 sub2 release", {31'd0, irq}, 32'd0);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFFD);
    settle();
    check("R8 main polarity inverts idle sub2", {31'd0, irq}, 32'd1);
    bus_write(U_MAIN, O_POL, 32'hFFFF_FFFF);
    settle();
    check("R8 polarity restored", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_level();
    t_latency();
    t_edge();
    t_enable();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule